// File: doc/BRIEF.md
# Streaming Fixed-Point Neuron Unit

This unit is one neuron of a fully connected layer. Signed 8-bit samples in Q1.7 format come in one per clock on a per-beat valid strobe. Each sample is multiplied by the weight for its position in the image. Those weights live in a small local store. The products are summed in a wide accumulator. When the final beat of an image arrives, the bias is scaled to the product format and added. The total is registered as the neuron output, and a single-cycle done flag is raised.

Weights and the bias come in over a load port that many neurons share. Each write carries a layer number and a neuron number. Only the unit whose build-time identifiers match both numbers captures the data, so one load bus can program a whole array of these units. The number of inputs per image is a parameter, 784 by default, which is one beat per pixel of a 28x28 image.

Top module: `neu_stream_unit`

## Requirements
- R1: Samples and weights are signed two's complement Q1.7 values. The result is signed Q(ACC_W-14).14: the sum over one image of sample*weight, plus the bias shifted left by 7 bits.
- R2: Only cycles with sample_valid_i high advance the computation. Cycles with sample_valid_i low, whatever sample_i holds, change neither the weight index nor the final result.
- R3: A load port write (cfg_we_i high) is taken only when cfg_layer_i equals LAYER_ID and cfg_neuron_i equals NEURON_ID. With cfg_bias_i=1 it writes the bias. With cfg_bias_i=0 it writes the weight at index cfg_addr_i. Any other write has no effect.
- R4: An image is NUM_IN valid beats (default 784). Beat k uses weight k. After the last beat the index wraps to 0, so the next image starts again at weight 0 with no reload.
- R5: The accumulator has ACC_W = 2*DATA_W + clog2(NUM_IN) + 1 bits (27 by default). It does not overflow even when every sample and weight is -128 or 127 and the bias is at either extreme.
- R6: result_o and done_o update in the cycle after the clock edge that samples the last beat. done_o is high for exactly that one cycle.
- R7: result_o keeps its value between images until the next image completes.
- R8: While rst_ni is low, the accumulator, the weight index, result_o and done_o are cleared to zero. Loaded weights and the bias are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample beat strobe |
| sample_i | input | DATA_W | Signed Q1.7 sample |
| cfg_we_i | input | 1 | Load port write strobe |
| cfg_bias_i | input | 1 | 1 selects the bias, 0 selects a weight |
| cfg_layer_i | input | LAYER_W | Target layer number |
| cfg_neuron_i | input | NEURON_W | Target neuron number |
| cfg_addr_i | input | clog2(NUM_IN) | Weight index |
| cfg_data_i | input | DATA_W | Signed Q1.7 weight or bias |
| result_o | output | ACC_W | Signed neuron output, 14 fractional bits |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
A weight index that is out of step with the beats makes every later product use the wrong weight. This shows up in result_o and done_o in the same cycle that the image ends. It also shows up in every image after it, because the index is never reloaded. The bench therefore runs images back to back, with and without idle gaps, and again after a reset in the middle of an image. A leftover accumulator value, or a write taken by the wrong neuron, shifts the very next result by a value the bench can predict. Samples and weights that vary per index make a shifted or stuck index visible, where constant values would hide it.

// File: rtl/neu_pkg.sv
package neu_pkg;
  typedef enum logic {
    CFG_WEIGHT = 1'b0,
    CFG_BIAS   = 1'b1
  } cfg_tgt_e;
endpackage

// File: rtl/neu_param_store.sv
module neu_param_store
  import neu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_IN    = 784,
  parameter int ADDR_W    = 10,
  parameter int LAYER_W   = 4,
  parameter int NEURON_W  = 6,
  parameter int LAYER_ID  = 1,
  parameter int NEURON_ID = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic                cfg_bias_i,
  input  logic [LAYER_W-1:0]  cfg_layer_i,
  input  logic [NEURON_W-1:0] cfg_neuron_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [DATA_W-1:0]   cfg_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   weight_o,
  output logic [DATA_W-1:0]   bias_o
);
  localparam logic [LAYER_W-1:0]  MY_LAYER  = LAYER_W'(LAYER_ID);
  localparam logic [NEURON_W-1:0] MY_NEURON = NEURON_W'(NEURON_ID);
  localparam logic [ADDR_W-1:0]   LAST_IDX  = ADDR_W'(NUM_IN - 1);

  logic [DATA_W-1:0] mem_q [NUM_IN];
  logic [DATA_W-1:0] bias_q;
  logic              hit;
  cfg_tgt_e          tgt;

  assign hit = cfg_we_i && (cfg_layer_i == MY_LAYER) && (cfg_neuron_i == MY_NEURON);
  assign tgt = cfg_tgt_e'(cfg_bias_i);

  // parameter storage survives reset
  always_ff @(posedge clk_i) begin
    if (hit && tgt == CFG_WEIGHT && cfg_addr_i <= LAST_IDX) mem_q[cfg_addr_i] <= cfg_data_i;
    if (hit && tgt == CFG_BIAS) bias_q <= cfg_data_i;
  end

  assign weight_o = mem_q[rd_addr_i];
  assign bias_o   = bias_q;

  // R3: foreign writes leave the bias untouched
  a_r3_bias_guarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit && tgt == CFG_BIAS) |=> $stable(bias_o));
endmodule

// File: rtl/neu_seq.sv
module neu_seq #(
  parameter int NUM_IN = 784,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_IN - 1);

  logic [ADDR_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           idx_q <= '0;
    else if (valid_i) begin
      if (idx_q == LAST_IDX) idx_q <= '0;
      else                   idx_q <= idx_q + 1'b1;
    end
  end

  assign rd_addr_o = idx_q;
  assign last_o    = (idx_q == LAST_IDX);

  a_r2_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(rd_addr_o));
  a_r4_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !last_o) |=> (rd_addr_o == $past(rd_addr_o) + 1'b1));
  a_r4_idx_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_o) |=> (rd_addr_o == '0));
endmodule

// File: rtl/neu_mac.sv
module neu_mac #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] weight_i,
  input  logic [DATA_W-1:0] bias_i,
  output logic [ACC_W-1:0]  result_o,
  output logic              done_o
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int FRAC_W = DATA_W - 1;
  localparam int BSGN_W = ACC_W - DATA_W - FRAC_W;

  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prod_ext, bias_ext, acc_q, acc_next, total;

  assign prod     = $signed(sample_i) * $signed(weight_i);
  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  // bias aligned to the Q.14 product scale
  assign bias_ext = {{BSGN_W{bias_i[DATA_W-1]}}, bias_i, {FRAC_W{1'b0}}};
  assign acc_next = acc_q + prod_ext;
  assign total    = acc_next + bias_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (valid_i) begin
        if (last_i) begin
          result_o <= total;
          acc_q    <= '0;
          done_o   <= 1'b1;
        end else begin
          acc_q <= acc_next;
        end
      end
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_q[ACC_W-1] == prod_ext[ACC_W-1]) |-> (acc_next[ACC_W-1] == acc_q[ACC_W-1]));
  a_r5_bias_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i && acc_next[ACC_W-1] == bias_ext[ACC_W-1])
      |-> (total[ACC_W-1] == acc_next[ACC_W-1]));
  a_r6_done_follows_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i) |=> done_o);
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

// File: rtl/neu_stream_unit.sv
module neu_stream_unit #(
  parameter int DATA_W    = 8,
  parameter int NUM_IN    = 784,
  parameter int LAYER_W   = 4,
  parameter int NEURON_W  = 6,
  parameter int LAYER_ID  = 1,
  parameter int NEURON_ID = 0,
  localparam int ADDR_W   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int ACC_W    = 2 * DATA_W + ADDR_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_valid_i,
  input  logic [DATA_W-1:0]   sample_i,
  input  logic                cfg_we_i,
  input  logic                cfg_bias_i,
  input  logic [LAYER_W-1:0]  cfg_layer_i,
  input  logic [NEURON_W-1:0] cfg_neuron_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [DATA_W-1:0]   cfg_data_i,
  output logic [ACC_W-1:0]    result_o,
  output logic                done_o
);
  logic [ADDR_W-1:0] rd_addr;
  logic              last;
  logic [DATA_W-1:0] weight, bias;

  neu_param_store #(
    .DATA_W(DATA_W), .NUM_IN(NUM_IN), .ADDR_W(ADDR_W), .LAYER_W(LAYER_W),
    .NEURON_W(NEURON_W), .LAYER_ID(LAYER_ID), .NEURON_ID(NEURON_ID)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_bias_i(cfg_bias_i),
    .cfg_layer_i(cfg_layer_i), .cfg_neuron_i(cfg_neuron_i), .cfg_addr_i(cfg_addr_i),
    .cfg_data_i(cfg_data_i), .rd_addr_i(rd_addr), .weight_o(weight), .bias_o(bias)
  );

  neu_seq #(.NUM_IN(NUM_IN), .ADDR_W(ADDR_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(sample_valid_i),
    .rd_addr_o(rd_addr), .last_o(last)
  );

  neu_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(sample_valid_i), .last_i(last),
    .sample_i(sample_i), .weight_i(weight), .bias_i(bias),
    .result_o(result_o), .done_o(done_o)
  );
endmodule

// File: tb/neu_stream_unit_tb_top.sv
module neu_stream_unit_tb_top;
  localparam int N   = 784;
  localparam int LID = 2;
  localparam int NID = 5;
  // each entry {sample, weight, bias}
  localparam logic [23:0] VEC [5] = '{24'h7F7F7F, 24'h808080, 24'h807F00, 24'h0005FF, 24'h40C00A};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] sample = '0;
  logic       we = 1'b0, bsel = 1'b0;
  logic [3:0] lay = '0;
  logic [5:0] neu = '0;
  logic [9:0] addr = '0;
  logic [7:0] data = '0;
  logic [26:0] result;
  logic        done;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  neu_stream_unit #(.LAYER_ID(LID), .NEURON_ID(NID)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sample_valid_i(valid), .sample_i(sample),
    .cfg_we_i(we), .cfg_bias_i(bsel), .cfg_layer_i(lay), .cfg_neuron_i(neu),
    .cfg_addr_i(addr), .cfg_data_i(data), .result_o(result), .done_o(done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pw(input int i); return 8'((i * 37) % 256); endfunction
  function automatic logic [7:0] ps(input int i); return 8'((i * 11 + 3) % 256); endfunction

  task automatic wr(input bit b, input int l, input int n, input int a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; bsel = b; lay = 4'(l); neu = 6'(n); addr = 10'(a); data = d;
  endtask

  task automatic wr_end();
    @(negedge clk); we = 1'b0;
  endtask

  // mode 0: constant sample s, mode 1: per-index pattern
  task automatic run_image(input int mode, input bit gaps, input logic [7:0] s, input int beats);
    for (int i = 0; i < beats; i++) begin
      if (gaps) begin
        @(negedge clk); valid = 1'b0; sample = 8'h5A;
      end
      @(negedge clk); valid = 1'b1; sample = (mode == 0) ? s : ps(i);
    end
    @(negedge clk); valid = 1'b0; sample = 8'hC3;
  endtask

  function automatic longint pat_exp(input int b);
    longint acc = 0;
    for (int i = 0; i < N; i++) acc += longint'($signed(ps(i))) * longint'($signed(pw(i)));
    return acc + longint'(b) * 128;
  endfunction

  task automatic check_done(input string tag, input longint exp);
    chk({tag, " done"}, longint'(done), 1);
    chk({tag, " result"}, longint'($signed(result)), exp);
    @(negedge clk);
    chk({tag, " R6 done one cycle"}, longint'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    longint pexp;
    repeat (3) @(negedge clk);
    chk("R8 reset result", longint'(result), 0);
    chk("R8 reset done", longint'(done), 0);
    rst_ni = 1'b1;

    // R1 R5: table of constant images at extremes
    for (int v = 0; v < 5; v++) begin
      logic signed [7:0] s, w, b;
      {s, w, b} = VEC[v];
      for (int i = 0; i < N; i++) wr(1'b0, LID, NID, i, w);
      wr(1'b1, LID, NID, 0, b);
      wr_end();
      run_image(0, 1'b0, s, N);
      check_done($sformatf("R1 R5 vec%0d", v), longint'(N) * s * w + longint'(b) * 128);
    end

    // R3: writes to other identifiers are ignored
    wr(1'b1, LID + 1, NID, 0, 8'h55);
    wr(1'b1, LID, NID + 1, 0, 8'h55);
    wr(1'b0, LID, NID + 1, 0, 8'h7F);
    wr(1'b0, LID + 1, NID, 3, 8'h7F);
    wr_end();
    run_image(0, 1'b0, 8'h40, N);
    check_done("R3 foreign writes", longint'(N) * 64 * -64 + 10 * 128);

    // R1 R4: per-index weights and samples, then a second image without reload
    for (int i = 0; i < N; i++) wr(1'b0, LID, NID, i, pw(i));
    wr(1'b1, LID, NID, 0, 8'hFD);
    wr_end();
    pexp = pat_exp(-3);
    run_image(1, 1'b0, 8'h00, N);
    check_done("R1 pattern", pexp);
    run_image(1, 1'b0, 8'h00, N);
    check_done("R4 wrap second image", pexp);

    // R2: idle beats between samples
    run_image(1, 1'b1, 8'h00, N);
    check_done("R2 gaps", pexp);

    // R7: result holds while idle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); sample = 8'(k * 71);
      chk("R7 hold", longint'($signed(result)), pexp);
      chk("R7 no done", longint'(done), 0);
    end

    // R8: reset in mid image clears state, parameters survive
    run_image(1, 1'b0, 8'h00, 100);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R8 mid reset result", longint'(result), 0);
    chk("R8 mid reset done", longint'(done), 0);
    rst_ni = 1'b1;
    run_image(1, 1'b0, 8'h00, N);
    check_done("R8 after reset", pexp);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule